// File: doc/BRIEF.md
# Mode-Dependent Memory Map Decoder

This block sits on the 16-bit address bus of a small microcontroller and decides, for every access, where it goes: the on-chip RAM and register file, the on-chip program memory, or the off-chip memory port. Two configuration inputs choose the map: an external-memory strap pin (`ext_pin`) and an enable bit from the status word (`ext_bit`). Together they select one of four configurations.

The two configurations with `ext_bit` low are single-chip maps. In these maps an access outside the RAM window and the top 16 KiB window is illegal. Such an access selects nothing and raises a one-clock pulse on `wdog_out` for the watchdog. The two configurations with `ext_bit` high open the middle of the space to the off-chip port, and they never raise the watchdog.

The configuration is kept in a four-state mode register named after the configurations: `MD_SC_NORMAL` ({pin,bit}=00), `MD_EXP_NORMAL` (01), `MD_SC_ROMLESS` (10) and `MD_EXP_ROMLESS` (11). On every clock edge the register loads the state named by the present {pin,bit}. This is a transition from any state to any state, including a hold to itself, and a reset transition leads to `MD_SC_NORMAL`. A decode uses the state already in the register. All select outputs and the watchdog pulse are registered.

Top module: `amap_decoder`

## Requirements
- R1: In every configuration, a valid access to 0x0000–0x02FF asserts `sel_ram` and no other output.
- R2: In `MD_SC_NORMAL` ({pin,bit}=00), a valid access to 0xC000–0xFFFF asserts `sel_rom`.
- R3: In `MD_EXP_NORMAL` ({pin,bit}=01), 0xC000–0xFFFF asserts `sel_rom` and 0x0300–0xBFFF asserts `sel_ext`.
- R4: In `MD_SC_ROMLESS` ({pin,bit}=10), 0xC000–0xFFFF asserts `sel_ext`, and `sel_rom` is never asserted while the pin is 1.
- R5: In `MD_EXP_ROMLESS` ({pin,bit}=11), every address from 0x0300 to 0xFFFF asserts `sel_ext`.
- R6: With the bit at 0, a valid access to 0x0300–0xBFFF asserts `wdog_out` and no select line.
- R7: With the bit at 1, `wdog_out` is never asserted, whatever the address.
- R8: At most one of `sel_ram`, `sel_rom`, `sel_ext` is high at a time. A legal valid access asserts exactly one of them. A cycle with `addr_vld` low asserts none of them.
- R9: The outputs are registered. The result of an access sampled at clock edge N is visible from edge N until edge N+1, so each illegal access gives exactly one cycle of `wdog_out`. Synchronous reset clears all outputs and sets the mode register to `MD_SC_NORMAL`.
- R10: The pin and bit are sampled at every edge. An access sampled at edge N is decoded with the pin and bit sampled at edge N-1, so a change applies from the next access onward.
- R11: `ext_en` is high exactly when `sel_ext` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Bus address |
| addr_vld | input | 1 | Access strobe for this cycle |
| ext_pin | input | 1 | External-memory strap pin |
| ext_bit | input | 1 | External-access enable bit |
| sel_ram | output | 1 | On-chip RAM/register select |
| sel_rom | output | 1 | On-chip program memory select |
| sel_ext | output | 1 | Off-chip memory select |
| ext_en | output | 1 | Off-chip port enable |
| wdog_out | output | 1 | One-cycle illegal-access pulse |

## Verification
An access driven before edge N has its select and watchdog result due in the window after edge N and before edge N+1. The decode for that access uses the pin and bit driven one cycle earlier. The driver sets the inputs on falling edges and queues each expected item with its due cycle, computed from the mode the bench itself last drove. The monitor compares the queued item shortly after the next falling edge, so each result is checked in the one cycle it is due. Mode switches and back-to-back illegal accesses fall out of the same queue timing.

// File: rtl/amap_pkg.sv
package amap_pkg;

    // Mode encoding is {ext_pin, ext_bit}
    typedef enum logic [1:0] {
        MD_SC_NORMAL   = 2'b00,
        MD_EXP_NORMAL  = 2'b01,
        MD_SC_ROMLESS  = 2'b10,
        MD_EXP_ROMLESS = 2'b11
    } amap_mode_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RAM,
        RG_ROM,
        RG_EXT,
        RG_BAD
    } amap_region_e;

    localparam int unsigned NUM_SEL = 3;
    localparam int unsigned SEL_RAM = 0;
    localparam int unsigned SEL_ROM = 1;
    localparam int unsigned SEL_EXT = 2;

endpackage

// File: rtl/amap_mode_fsm.sv
module amap_mode_fsm
    import amap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_pin,
    input  logic       ext_bit,
    output amap_mode_e mode,
    output logic       check_on
);

    amap_mode_e state_q;
    amap_mode_e state_d;

    // Next state: any configuration may follow any other
    always_comb begin
        unique case ({ext_pin, ext_bit})
            2'b00:   state_d = MD_SC_NORMAL;
            2'b01:   state_d = MD_EXP_NORMAL;
            2'b10:   state_d = MD_SC_ROMLESS;
            default: state_d = MD_EXP_ROMLESS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MD_SC_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs of the state
    always_comb begin
        mode = state_q;
        unique case (state_q)
            MD_SC_NORMAL,
            MD_SC_ROMLESS:  check_on = 1'b1;
            MD_EXP_NORMAL,
            MD_EXP_ROMLESS: check_on = 1'b0;
            default:        check_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/amap_region_decode.sv
module amap_region_decode
    import amap_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  RAM_LAST  = 16'h02FF,
    parameter logic [ADDR_W-1:0]  ROM_FIRST = 16'hC000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_vld,
    input  amap_mode_e        mode,
    input  logic              check_on,
    output amap_region_e      region
);

    logic in_ram;
    logic in_top;

    assign in_ram = (addr <= RAM_LAST);
    assign in_top = (addr >= ROM_FIRST);

    always_comb begin
        region = RG_NONE;
        if (addr_vld) begin
            if (in_ram) begin
                region = RG_RAM;
            end else if (in_top) begin
                unique case (mode)
                    MD_SC_NORMAL,
                    MD_EXP_NORMAL:  region = RG_ROM;
                    MD_SC_ROMLESS,
                    MD_EXP_ROMLESS: region = RG_EXT;
                    default:        region = RG_NONE;
                endcase
            end else begin
                region = check_on ? RG_BAD : RG_EXT;
            end
        end
    end

endmodule

// File: rtl/amap_out_stage.sv
module amap_out_stage
    import amap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  amap_region_e       region,
    output logic [NUM_SEL-1:0] sel,
    output logic               ext_en,
    output logic               wdog_out
);

    logic [NUM_SEL-1:0] sel_d;

    // One select bit per legal region
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        localparam amap_region_e RG_OF_BIT =
            (g == SEL_RAM) ? RG_RAM : ((g == SEL_ROM) ? RG_ROM : RG_EXT);
        assign sel_d[g] = (region == RG_OF_BIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel      <= '0;
            ext_en   <= 1'b0;
            wdog_out <= 1'b0;
        end else begin
            sel      <= sel_d;
            ext_en   <= (region == RG_EXT);
            wdog_out <= (region == RG_BAD);
        end
    end

endmodule

// File: rtl/amap_decoder.sv
module amap_decoder
    import amap_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] RAM_LAST  = 16'h02FF,
    parameter logic [ADDR_W-1:0] ROM_FIRST = 16'hC000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_vld,
    input  logic              ext_pin,
    input  logic              ext_bit,
    output logic              sel_ram,
    output logic              sel_rom,
    output logic              sel_ext,
    output logic              ext_en,
    output logic              wdog_out
);

    amap_mode_e         mode;
    logic               check_on;
    amap_region_e       region;
    logic [NUM_SEL-1:0] sel;

    amap_mode_fsm u_mode (
        .clk      (clk),
        .rst      (rst),
        .ext_pin  (ext_pin),
        .ext_bit  (ext_bit),
        .mode     (mode),
        .check_on (check_on)
    );

    amap_region_decode #(
        .ADDR_W    (ADDR_W),
        .RAM_LAST  (RAM_LAST),
        .ROM_FIRST (ROM_FIRST)
    ) u_dec (
        .addr     (addr),
        .addr_vld (addr_vld),
        .mode     (mode),
        .check_on (check_on),
        .region   (region)
    );

    amap_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .region   (region),
        .sel      (sel),
        .ext_en   (ext_en),
        .wdog_out (wdog_out)
    );

    assign sel_ram = sel[SEL_RAM];
    assign sel_rom = sel[SEL_ROM];
    assign sel_ext = sel[SEL_EXT];

endmodule

// File: rtl/amap_decoder_chk.sv
module amap_decoder_chk #(
    parameter int unsigned       ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RAM_LAST = 16'h02FF
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_vld,
    input logic              ext_pin,
    input logic              ext_bit,
    input logic              sel_ram,
    input logic              sel_rom,
    input logic              sel_ext,
    input logic              ext_en,
    input logic              wdog_out
);

    // Edges seen since reset was released, saturating
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_ram, sel_rom, sel_ext}));

    p_ext_en_match_r11: assert property (@(posedge clk) disable iff (rst)
        ext_en == sel_ext);

    p_wdog_nosel_r6: assert property (@(posedge clk) disable iff (rst)
        wdog_out |-> !(sel_ram || sel_rom || sel_ext));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
        !$past(addr_vld) |-> !(sel_ram || sel_rom || sel_ext || wdog_out));

    p_ram_hit_r1: assert property (@(posedge clk) disable iff (rst || age == 2'd0)
        $past(addr_vld && (addr <= RAM_LAST)) |-> sel_ram);

    p_no_wdog_r7: assert property (@(posedge clk) disable iff (rst || age < 2'd2)
        wdog_out |-> !$past(ext_bit, 2));

    p_rom_pin_low_r4: assert property (@(posedge clk) disable iff (rst || age < 2'd2)
        sel_rom |-> !$past(ext_pin, 2));

endmodule

bind amap_decoder amap_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .RAM_LAST (RAM_LAST)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .addr_vld (addr_vld),
    .ext_pin  (ext_pin),
    .ext_bit  (ext_bit),
    .sel_ram  (sel_ram),
    .sel_rom  (sel_rom),
    .sel_ext  (sel_ext),
    .ext_en   (ext_en),
    .wdog_out (wdog_out)
);

// File: tb/amap_decoder_tb.sv
module amap_decoder_tb;

    typedef struct {
        int         due;
        logic [2:0] sel;   // {ext, rom, ram}
        logic       wd;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        addr_vld = 1'b0;
    logic        ext_pin = 1'b0;
    logic        ext_bit = 1'b0;
    logic        sel_ram, sel_rom, sel_ext, ext_en, wdog_out;

    int   checks   = 0;
    int   failures = 0;
    int   cyc      = 0;
    bit   done     = 1'b0;
    exp_t q[$];
    logic [1:0] prev_mode = 2'b00;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    amap_decoder u_dut (
        .clk(clk), .rst(rst), .addr(addr), .addr_vld(addr_vld),
        .ext_pin(ext_pin), .ext_bit(ext_bit),
        .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_ext(sel_ext),
        .ext_en(ext_en), .wdog_out(wdog_out)
    );

    function automatic exp_t model(input logic [1:0] md, input logic [15:0] a,
                                   input logic v);
        exp_t e;
        e.due = 0; e.sel = 3'b000; e.wd = 1'b0; e.tag = "";
        if (v) begin
            if (a <= 16'h02FF)       e.sel = 3'b001;
            else if (a >= 16'hC000)  e.sel = md[1] ? 3'b100 : 3'b010;
            else if (md[0])          e.sel = 3'b100;
            else                     e.wd  = 1'b1;
        end
        return e;
    endfunction

    // Driver: called just after a falling edge
    task automatic drive(input logic [15:0] a, input logic v, input logic p,
                         input logic b, input string tag);
        exp_t e;
        addr = a; addr_vld = v; ext_pin = p; ext_bit = b;
        e = model(prev_mode, a, v);
        e.due = cyc + 1;
        e.tag = tag;
        q.push_back(e);
        prev_mode = {p, b};
        @(negedge clk);
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                logic [2:0] act;
                e = q.pop_front();
                act = {sel_ext, sel_rom, sel_ram};
                checks++;
                if (act !== e.sel || wdog_out !== e.wd || ext_en !== e.sel[2]) begin
                    failures++;
                    $display("FAIL %s: actual sel=%b wd=%b ext_en=%b expected sel=%b wd=%b ext_en=%b",
                             e.tag, act, wdog_out, ext_en, e.sel, e.wd, e.sel[2]);
                end
            end
        end
    end

    task automatic check_zero(input string tag);
        checks++;
        if ({sel_ram, sel_rom, sel_ext, ext_en, wdog_out} !== 5'b0) begin
            failures++;
            $display("FAIL %s: actual outs=%b expected outs=00000", tag,
                     {sel_ram, sel_rom, sel_ext, ext_en, wdog_out});
        end
    endtask

    initial begin
        // R9: reset clears outputs even with an illegal access presented
        addr = 16'h4000; addr_vld = 1'b1;
        repeat (3) @(negedge clk);
        #1 check_zero("R9 reset");
        rst = 1'b0; prev_mode = 2'b00;

        // Mode 00
        drive(16'h0000, 1, 0, 0, "R1 ram low 00");
        drive(16'h02FF, 1, 0, 0, "R1 ram high 00");
        drive(16'h0300, 1, 0, 0, "R6 illegal 0300");
        drive(16'hBFFF, 1, 0, 0, "R6 illegal BFFF");
        drive(16'h0000, 0, 0, 0, "R9 single pulse then idle");
        drive(16'hC000, 1, 0, 0, "R2 rom C000");
        drive(16'hFFFF, 1, 0, 0, "R2 rom FFFF");
        drive(16'h8000, 0, 0, 0, "R8 no select when idle");
        // R10: switch to 01 with a mid access: still decoded as 00
        drive(16'h5000, 1, 0, 1, "R10 old mode applies");
        drive(16'h0300, 1, 0, 1, "R3 ext 0300");
        drive(16'hBFFF, 1, 0, 1, "R3 ext BFFF");
        drive(16'hC000, 1, 0, 1, "R3 rom C000");
        drive(16'h0100, 1, 0, 1, "R1 ram 01");
        drive(16'h4000, 1, 0, 1, "R7 no wdog 01");
        // Mode 10 (first access decoded as 01)
        drive(16'hC000, 1, 1, 0, "R10 rom before romless");
        drive(16'hC000, 1, 1, 0, "R4 ext C000");
        drive(16'hFFFF, 1, 1, 0, "R4 ext FFFF");
        drive(16'h0300, 1, 1, 0, "R6 illegal romless");
        drive(16'h0200, 1, 1, 0, "R1 ram 10");
        // Mode 11 (first access decoded as 10)
        drive(16'h7000, 1, 1, 1, "R10 illegal before expanded");
        drive(16'h0300, 1, 1, 1, "R5 ext 0300");
        drive(16'hFFFF, 1, 1, 1, "R5 ext FFFF");
        drive(16'h8000, 1, 1, 1, "R7 no wdog 11");
        drive(16'h0000, 1, 1, 1, "R1 ram 11");
        drive(16'h0000, 0, 1, 1, "R8 idle 11");
        // Back to 00, consecutive illegal accesses
        drive(16'h0000, 0, 0, 0, "R8 idle switch");
        drive(16'h1000, 1, 0, 0, "R6 illegal burst 1");
        drive(16'h2000, 1, 0, 0, "R6 illegal burst 2");
        drive(16'h0000, 0, 0, 0, "R9 pulse ends");
        drive(16'h0000, 0, 0, 0, "R8 idle tail");
        @(negedge clk);
        @(negedge clk);
        // R9: reset during an illegal access clears everything
        addr = 16'h3000; addr_vld = 1'b1; rst = 1'b1;
        @(negedge clk);
        #1 check_zero("R9 reset mid-run");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule